// File: doc/BRIEF.md
# Start-Stop Timed Shift Register

This block is a shift register of `WIDTH` bits whose contents drive a row of LEDs. It runs entirely on the fast system clock. A clock divider produces a one-cycle tick every `TICK_DIV` clocks, and the register moves one place on each tick. With the 50 MHz default and `TICK_DIV` = 5,000,000, that is one step about every 0.1 s. A pushbutton starts and stops the motion. A small state machine looks for the moment the button goes from released to pressed, and each such press flips the run flag. An active-low reset clears the register and the divider, and leaves the block stopped.

The serial bit and the button are plain level inputs, and the LED word and run flag are plain level outputs. No data crosses a handshake here, so no valid/ready pair is used and nothing can apply back-pressure. The serial bit is taken only on the clock edge that carries a shift. The button first passes through a synchronizer of `SYNC_STAGES` flops. While the block is stopped the divider is held at zero, so the first step after a start always comes one full interval later.

Top module: `start_stop_shifter`

## Requirements
- R1: While `rst_n` is low, `leds` reads all zeros and `running` reads 0. After reset is released they stay that way until a press is seen.
- R2: A rise of `btn_press` that is seen after the button was released flips `running`. With `SYNC_STAGES` = 2, the new value appears on the third rising clock edge after the rise.
- R3: Holding the button down flips `running` only once, and releasing the button never changes `running`.
- R4: While `running` is 0, `leds` keeps its value whatever `ser_in` does.
- R5: While running, the register moves exactly once every `TICK_DIV` clocks. The first move comes on the `TICK_DIV`-th edge after the edge that set `running`.
- R6: On each move, `ser_in` enters `leds[0]`, each `leds[i]` moves to `leds[i+1]`, and the old `leds[WIDTH-1]` is lost.
- R7: Stopping discards any partly counted interval, and reset clears the divider. A move still happens on the stopping edge if the interval completes on that edge. After a restart, a full `TICK_DIV` clocks pass before the next move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| btn_press | input | 1 | Start/stop button, 1 = pressed, asynchronous |
| ser_in | input | 1 | Serial bit shifted into bit 0 |
| leds | output | WIDTH | Shift register contents |
| running | output | 1 | 1 while the register is advancing |

## Verification
A wrong divider count shows up at `leds` no later than one interval after the start: the first move arrives early or late against the `TICK_DIV` schedule. A press state machine stuck in its held state shows up at `running` on the next press, which fails to flip it. A wrong run flag shows up within three edges of a press. Each step is compared every cycle against a count of moves computed from the number of edges since the start. Stop points are placed both on and off an interval boundary, so leftover divider state after a pause would show on the first step after the restart.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic {
    BTN_UP   = 1'b0,
    BTN_HELD = 1'b1
  } btn_state_e;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sss_toggle_fsm.sv
module sss_toggle_fsm
  import sss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic run,
  output logic armed
);
  btn_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BTN_UP;
      run   <= 1'b0;
    end else begin
      case (state)
        BTN_UP: begin
          if (btn) begin
            state <= BTN_HELD;
            run   <= ~run;
          end
        end
        BTN_HELD: begin
          if (!btn) state <= BTN_UP;
        end
        default: state <= BTN_UP;
      endcase
    end
  end

  assign armed = (state == BTN_UP);
endmodule

// File: rtl/sss_tick_div.sv
module sss_tick_div #(
  parameter int DIV = 5000000,
  parameter int CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          tick,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic at_last;
  assign at_last = (cnt == LAST);
  assign tick    = run & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || at_last)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sss_shreg.sv
module sss_shreg #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/start_stop_shifter.sv
module start_stop_shifter #(
  parameter int WIDTH       = 10,
  parameter int TICK_DIV    = 5000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_press,
  input  logic             ser_in,
  output logic [WIDTH-1:0] leds,
  output logic             running
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic             btn_s;
  logic             fsm_idle;
  logic             tick;
  logic [CNT_W-1:0] div_cnt;

  sss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_press),
    .q     (btn_s)
  );

  sss_toggle_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .btn   (btn_s),
    .run   (running),
    .armed (fsm_idle)
  );

  sss_tick_div #(.DIV(TICK_DIV), .CW(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .tick  (tick),
    .cnt   (div_cnt)
  );

  sss_shreg #(.WIDTH(WIDTH)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (tick),
    .din      (ser_in),
    .q        (leds)
  );
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int WIDTH    = 10,
  parameter int TICK_DIV = 5000000,
  parameter int CNT_W    = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] leds,
  input logic             running,
  input logic             tick,
  input logic [CNT_W-1:0] div_cnt,
  input logic             btn_s,
  input logic             fsm_idle
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (leds == '0 && !running));

  // R2
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running != $past(running)) |-> ($past(btn_s) && $past(fsm_idle)));

  // R3
  held_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsm_idle && btn_s) |=> (running == $past(running)));

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(leds));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= CNT_W'(TICK_DIV - 1));

  // R6
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (leds == {$past(leds[WIDTH-2:0]), $past(ser_in)}));

  // R7
  stop_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (div_cnt == '0));
endmodule

bind start_stop_shifter sss_checker #(
  .WIDTH(WIDTH), .TICK_DIV(TICK_DIV), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .leds     (leds),
  .running  (running),
  .tick     (tick),
  .div_cnt  (div_cnt),
  .btn_s    (btn_s),
  .fsm_idle (fsm_idle)
);

// File: tb/start_stop_shifter_bench.sv
module start_stop_shifter_bench;
  localparam int W = 10;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         btn_press;
  logic         ser_in;
  logic [W-1:0] leds;
  logic         running;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  start_stop_shifter #(.WIDTH(W), .TICK_DIV(D), .SYNC_STAGES(2)) u_start_stop_shifter (
    .clk(clk), .rst_n(rst_n), .btn_press(btn_press), .ser_in(ser_in),
    .leds(leds), .running(running)
  );

  function automatic logic pbit(int seed, int j);
    logic [15:0] p;
    p = 16'((j + 1) * seed * 37 + j);
    return ^p;
  endfunction

  function automatic logic [W-1:0] expect_leds(logic [W-1:0] v0, int seed, int n);
    logic [W-1:0] v;
    v = v0;
    for (int j = 0; j < n; j++) v = {v[W-2:0], pbit(seed, j)};
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Press from the stopped state, then step k = 0..k_end from the start edge.
  // k_stop >= 0 presses again at k_stop, so running falls at edge k_stop+3.
  task automatic run_seg(int seed, logic [W-1:0] v0, int k_stop, int k_end,
                         output logic [W-1:0] v_end);
    int s;
    int s_cap;
    bit exp_run;
    @(negedge clk);
    btn_press = 1'b1;
    ser_in    = pbit(seed, 0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R2 not yet toggled", running, 0);
    @(posedge clk);
    s_cap = (k_stop >= 0) ? (k_stop + 3) / D : 1 << 30;
    for (int k = 0; k <= k_end; k++) begin
      @(negedge clk);
      s       = (k / D < s_cap) ? k / D : s_cap;
      exp_run = (k_stop < 0) ? 1'b1 : (k < k_stop + 3);
      check(exp_run ? "R3 R5 running" : "R2 stop running", running, exp_run);
      check(exp_run ? "R5 R6 leds" : "R4 R7 leds", leds, expect_leds(v0, seed, s));
      btn_press = (k < 5) || (k_stop >= 0 && k >= k_stop && k < k_stop + 6);
      ser_in    = pbit(seed, k / D);
      v_end     = expect_leds(v0, seed, s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 1'b0; btn_press = 1'b0; ser_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset leds", leds, 0);
    check("R1 reset running", running, 0);
    rst_n = 1'b1;
    // R4: stopped after reset, serial input wiggles
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ser_in = i[0] ^ i[2];
      check("R4 idle leds", leds, 0);
      check("R1 idle running", running, 0);
    end
    // stop lands on an interval boundary (12): move on the stopping edge
    run_seg(5, '0, 9, 30, v);
    // stop mid-interval (13): progress discarded, restart waits a full interval
    run_seg(11, v, 10, 30, v);
    // long run with full turnover of the register
    run_seg(23, v, -1, 4 * W + 8, v);
    // reset while running
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async leds", leds, 0);
    check("R1 async running", running, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ser_in = ~ser_in;
      check("R4 after reset leds", leds, 0);
      check("R1 after reset running", running, 0);
    end
    // R7: divider cleared by reset, first move exactly D edges after start
    run_seg(3, '0, -1, 3 * D, v);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule